// File: doc/BRIEF.md
# Backplane Slave Cycle Decoder

This block sits behind the backplane interface of a register-based module. It receives slave cycles: address, address-modifier code, byte-lane enables and direction, framed by an address strobe and a data strobe. It decides whether a cycle belongs to the module. A cycle that does not belong to it draws no reply, so another slave can answer.

The module answers in three places:
- a small configuration window in short (16-bit) I/O space;
- in the default mode, a 16 MB window in 32-bit address space;
- when a strap input is set, a 4 MB window in 24-bit address space instead.

When a cycle is accepted, the block checks the byte-lane pattern. A legal beat becomes a request on the local bus, carrying the space, the offset inside the window, the byte lanes and the direction. The local acknowledge is passed back as a data acknowledge.

An illegal lane pattern gets a bus error at once. A local bus that stays silent for the timeout period also gets a bus error.

Block-transfer codes allow several beats under one address strobe, and the offset steps forward by the size of each beat.

Top module: `bus_slave_decoder`

## Requirements
- R1: Modifier codes 0x29 and 0x2D select short I/O space. A cycle hits when busAddr[15:6] equals CFG_BASE[15:6]. The request then carries locSpace=0 and locOffset=busAddr[5:0].
- R2: With strapNarrow=0, the wide-space codes are accepted: 0x09, 0x0A, 0x0D and 0x0E as single cycles, and 0x0B and 0x0F as block cycles. A cycle hits when busAddr[31:24] equals A32_BASE[31:24]. The request then carries locSpace=1 and locOffset=busAddr[23:0].
- R3: With strapNarrow=1, the narrow-space codes are accepted: 0x39, 0x3A, 0x3D and 0x3E as single cycles, and 0x3B and 0x3F as block cycles. A cycle hits when busAddr[23:22] equals A24_BASE[23:22]. The request then carries locSpace=1 and locOffset=busAddr[21:0].
- R4: The following cycles are ignored and produce no locReq, no busAck and no busBerr:
  - a cycle with a wide-space code while strapNarrow=1;
  - a cycle with a narrow-space code while strapNarrow=0;
  - a cycle with any other modifier code;
  - a cycle whose address misses the window.
- R5: busLanes bit i enables byte i. The legal patterns are 0001, 0010, 0100, 1000, 0011, 1100 and 1111. A legal beat raises locReq with locLanes equal to busLanes and locWrite equal to busWrite. The beat ends with busAck after locAck.
- R6: Any other lane pattern on a hit cycle (three bytes, the middle pair 0110, 0000 and the rest) is answered with busBerr, and locReq is never raised.
- R7: If locAck does not arrive, locReq is held for exactly TIMEOUT_CYCLES clocks. It is then dropped and busBerr is given.
- R8: Under a block code, each data strobe inside one address strobe is a new beat. The offset of each beat is the previous beat's offset plus the number of enabled bytes in the previous beat. Under a single-cycle code, only the first beat is served, and later data strobes inside the same address strobe are ignored.
- R9: busAck and busBerr are one-clock pulses, never high together, and there is one of them per served beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapNarrow | input | 1 | 1 selects the 24-bit window, 0 the 32-bit window |
| busAddrStrobe | input | 1 | High for the whole slave cycle, including all block beats |
| busDataStrobe | input | 1 | High for one beat |
| busAm | input | 6 | Address-modifier code |
| busAddr | input | 32 | Cycle address, sampled when the address strobe rises |
| busLanes | input | 4 | Byte-lane enables, sampled at each beat |
| busWrite | input | 1 | 1 for a write beat |
| busAck | output | 1 | Data-acknowledge pulse |
| busBerr | output | 1 | Bus-error pulse |
| locReq | output | 1 | Local bus request, held until locAck or timeout |
| locSpace | output | 1 | 0 for the configuration window, 1 for the wide window |
| locOffset | output | 24 | Byte offset inside the window |
| locLanes | output | 4 | Byte lanes of the local request |
| locWrite | output | 1 | Direction of the local request |
| locAck | input | 1 | Local bus completion |

## Verification
The hardest case to reach is the local-bus timeout: it only occurs when the far side never answers. The bench's local responder has an enable that the timeout scenario switches off. The bench then counts every clock during which the request is held and expects exactly the timeout count before the bus error. Block-beat offset stepping is reached by keeping the address strobe high and pulsing the data strobe several times with mixed lane sizes.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  typedef enum logic [2:0] {
    AM_NONE,
    AM_SHORT,
    AM_WIDE_SGL,
    AM_WIDE_BLK,
    AM_NARROW_SGL,
    AM_NARROW_BLK
  } amKind_t;

  typedef struct packed {
    logic latchAddr;
    logic latchBeat;
    logic advance;
  } bsdStrobes_t;

endpackage

// File: rtl/bsd_datapath.sv
module bsd_datapath
  import bsd_pkg::*;
#(
  parameter logic [15:0] CFG_BASE      = 16'hC040,
  parameter int          CFG_WIN_LOG2  = 6,
  parameter logic [31:0] A32_BASE      = 32'h2000_0000,
  parameter int          A32_WIN_LOG2  = 24,
  parameter logic [23:0] A24_BASE      = 24'h40_0000,
  parameter int          A24_WIN_LOG2  = 22,
  localparam int         OFF_W         = A32_WIN_LOG2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapNarrow,
  input  logic [5:0]       busAm,
  input  logic [31:0]      busAddr,
  input  logic [3:0]       busLanes,
  input  logic             busWrite,
  input  bsdStrobes_t      strobes,
  output logic             hit,
  output logic             isBlock,
  output logic             lanesOk,
  output logic             locSpace,
  output logic [OFF_W-1:0] locOffset,
  output logic [3:0]       locLanes,
  output logic             locWrite
);

  amKind_t            amKind;
  logic               hitNext;
  logic               blockNext;
  logic               spaceNext;
  logic [OFF_W-1:0]   offsetNext;
  logic [2:0]         beatBytes;

  // Classify the modifier code into the accepted families
  always_comb begin
    case (busAm)
      6'h29, 6'h2D:                amKind = AM_SHORT;
      6'h09, 6'h0A, 6'h0D, 6'h0E:  amKind = AM_WIDE_SGL;
      6'h0B, 6'h0F:                amKind = AM_WIDE_BLK;
      6'h39, 6'h3A, 6'h3D, 6'h3E:  amKind = AM_NARROW_SGL;
      6'h3B, 6'h3F:                amKind = AM_NARROW_BLK;
      default:                     amKind = AM_NONE;
    endcase
  end

  // Window match and offset extraction for the code family
  always_comb begin
    hitNext    = 1'b0;
    blockNext  = 1'b0;
    spaceNext  = 1'b1;
    offsetNext = '0;
    case (amKind)
      AM_SHORT: begin
        hitNext    = busAddr[15:CFG_WIN_LOG2] == CFG_BASE[15:CFG_WIN_LOG2];
        spaceNext  = 1'b0;
        offsetNext = OFF_W'(busAddr[CFG_WIN_LOG2-1:0]);
      end
      AM_WIDE_SGL, AM_WIDE_BLK: begin
        hitNext    = !strapNarrow &&
                     (busAddr[31:A32_WIN_LOG2] == A32_BASE[31:A32_WIN_LOG2]);
        blockNext  = amKind == AM_WIDE_BLK;
        offsetNext = OFF_W'(busAddr[A32_WIN_LOG2-1:0]);
      end
      AM_NARROW_SGL, AM_NARROW_BLK: begin
        hitNext    = strapNarrow &&
                     (busAddr[23:A24_WIN_LOG2] == A24_BASE[23:A24_WIN_LOG2]);
        blockNext  = amKind == AM_NARROW_BLK;
        offsetNext = OFF_W'(busAddr[A24_WIN_LOG2-1:0]);
      end
      default: ;
    endcase
  end

  // Byte count of the latched beat
  always_comb begin
    beatBytes = '0;
    for (int i = 0; i < 4; i++) begin
      beatBytes = beatBytes + 3'(locLanes[i]);
    end
  end

  // Naturally aligned sizes only
  always_comb begin
    case (locLanes)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: lanesOk = 1'b1;
      default:                   lanesOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit       <= 1'b0;
      isBlock   <= 1'b0;
      locSpace  <= 1'b0;
      locOffset <= '0;
      locLanes  <= '0;
      locWrite  <= 1'b0;
    end else begin
      if (strobes.latchAddr) begin
        hit       <= hitNext;
        isBlock   <= blockNext;
        locSpace  <= spaceNext;
        locOffset <= offsetNext;
      end else if (strobes.advance) begin
        locOffset <= locOffset + OFF_W'(beatBytes);
      end
      if (strobes.latchBeat) begin
        locLanes <= busLanes;
        locWrite <= busWrite;
      end
    end
  end

endmodule

// File: rtl/bsd_control.sv
module bsd_control
  import bsd_pkg::*;
#(
  parameter int  TIMEOUT_CYCLES = 256,
  localparam int CNT_W          = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busAddrStrobe,
  input  logic        busDataStrobe,
  input  logic        hit,
  input  logic        isBlock,
  input  logic        lanesOk,
  input  logic        locAck,
  output bsdStrobes_t strobes,
  output logic        locReq,
  output logic        busAck,
  output logic        busBerr
);

  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_WAIT_DS, S_CHECK, S_REQ, S_DONE, S_HOLD
  } state_t;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  state_t           state, stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic             ackSet, berrSet;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    ackSet    = 1'b0;
    berrSet   = 1'b0;
    case (state)
      S_IDLE: if (busAddrStrobe) begin
        strobes.latchAddr = 1'b1;
        stateNext         = S_DECODE;
      end
      S_DECODE: stateNext = hit ? S_WAIT_DS : S_HOLD;
      S_WAIT_DS: begin
        if (!busAddrStrobe) begin
          stateNext = S_IDLE;
        end else if (busDataStrobe) begin
          strobes.latchBeat = 1'b1;
          stateNext         = S_CHECK;
        end
      end
      S_CHECK: begin
        berrSet   = !lanesOk;
        stateNext = lanesOk ? S_REQ : S_DONE;
      end
      S_REQ: begin
        if (locAck) begin
          ackSet          = 1'b1;
          strobes.advance = 1'b1;
          stateNext       = S_DONE;
        end else if (waitCnt == CNT_LAST) begin
          berrSet   = 1'b1;
          stateNext = S_DONE;
        end
      end
      S_DONE: if (!busDataStrobe) begin
        stateNext = (isBlock && busAddrStrobe) ? S_WAIT_DS : S_HOLD;
      end
      S_HOLD: if (!busAddrStrobe) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      busAck  <= 1'b0;
      busBerr <= 1'b0;
    end else begin
      state   <= stateNext;
      waitCnt <= (state == S_REQ) ? waitCnt + 1'b1 : '0;
      busAck  <= ackSet;
      busBerr <= berrSet;
    end
  end

  assign locReq = state == S_REQ;

endmodule

// File: rtl/bus_slave_decoder.sv
module bus_slave_decoder
  import bsd_pkg::*;
#(
  parameter logic [15:0] CFG_BASE       = 16'hC040,
  parameter int          CFG_WIN_LOG2   = 6,
  parameter logic [31:0] A32_BASE       = 32'h2000_0000,
  parameter int          A32_WIN_LOG2   = 24,
  parameter logic [23:0] A24_BASE       = 24'h40_0000,
  parameter int          A24_WIN_LOG2   = 22,
  parameter int          TIMEOUT_CYCLES = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strapNarrow,
  input  logic        busAddrStrobe,
  input  logic        busDataStrobe,
  input  logic [5:0]  busAm,
  input  logic [31:0] busAddr,
  input  logic [3:0]  busLanes,
  input  logic        busWrite,
  output logic        busAck,
  output logic        busBerr,
  output logic        locReq,
  output logic        locSpace,
  output logic [23:0] locOffset,
  output logic [3:0]  locLanes,
  output logic        locWrite,
  input  logic        locAck
);

  bsdStrobes_t strobes;
  logic        hit, isBlock, lanesOk;

  bsd_datapath #(
    .CFG_BASE(CFG_BASE), .CFG_WIN_LOG2(CFG_WIN_LOG2),
    .A32_BASE(A32_BASE), .A32_WIN_LOG2(A32_WIN_LOG2),
    .A24_BASE(A24_BASE), .A24_WIN_LOG2(A24_WIN_LOG2)
  ) u_path (
    .clk(clk), .rstN(rstN), .strapNarrow(strapNarrow),
    .busAm(busAm), .busAddr(busAddr), .busLanes(busLanes), .busWrite(busWrite),
    .strobes(strobes), .hit(hit), .isBlock(isBlock), .lanesOk(lanesOk),
    .locSpace(locSpace), .locOffset(locOffset), .locLanes(locLanes),
    .locWrite(locWrite)
  );

  bsd_control #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddrStrobe(busAddrStrobe), .busDataStrobe(busDataStrobe),
    .hit(hit), .isBlock(isBlock), .lanesOk(lanesOk), .locAck(locAck),
    .strobes(strobes), .locReq(locReq), .busAck(busAck), .busBerr(busBerr)
  );

endmodule

// File: rtl/bsd_checker.sv
module bsd_checker #(
  parameter int TIMEOUT_CYCLES = 256
) (
  input logic        clk,
  input logic        rstN,
  input logic        busAck,
  input logic        busBerr,
  input logic        locReq,
  input logic        locAck,
  input logic [3:0]  locLanes,
  input logic [23:0] locOffset
);

  logic [31:0] reqRun;
  logic        lanesLegal;

  always_ff @(posedge clk) begin
    if (!rstN)       reqRun <= '0;
    else if (locReq) reqRun <= reqRun + 1;
    else             reqRun <= '0;
  end

  always_comb begin
    case (locLanes)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: lanesLegal = 1'b1;
      default:                   lanesLegal = 1'b0;
    endcase
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rstN) !(busAck && busBerr)); // R9
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN) busAck |=> !busAck); // R9
  AST_BERR_PULSE: assert property (@(posedge clk) disable iff (!rstN) busBerr |=> !busBerr); // R9
  AST_ACK_FROM_LOCAL: assert property (@(posedge clk) disable iff (!rstN) busAck |-> $past(locReq && locAck)); // R5
  AST_LEGAL_LANES: assert property (@(posedge clk) disable iff (!rstN) locReq |-> lanesLegal); // R6
  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rstN) reqRun <= TIMEOUT_CYCLES); // R7
  AST_REQ_ENDS_REPLIED: assert property (@(posedge clk) disable iff (!rstN) $fell(locReq) |-> (busAck || busBerr)); // R7
  AST_OFFSET_STABLE: assert property (@(posedge clk) disable iff (!rstN) (locReq && $past(locReq)) |-> $stable(locOffset)); // R8

endmodule

bind bus_slave_decoder bsd_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .busAck(busAck), .busBerr(busBerr), .locReq(locReq),
  .locAck(locAck), .locLanes(locLanes), .locOffset(locOffset)
);

// File: tb/bus_slave_decoder_tb.sv
module bus_slave_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 256;
  localparam int EXP_NONE = 0, EXP_ACK = 1, EXP_BERR = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapNarrow = 1'b0;
  logic        busAddrStrobe = 1'b0, busDataStrobe = 1'b0;
  logic [5:0]  busAm = '0;
  logic [31:0] busAddr = '0;
  logic [3:0]  busLanes = '0;
  logic        busWrite = 1'b0;
  logic        busAck, busBerr, locReq, locSpace, locWrite;
  logic [23:0] locOffset;
  logic [3:0]  locLanes;
  logic        locAck = 1'b0;

  int  errors = 0, checks = 0;
  bit  respOn = 1'b1;
  int  reqCycles;
  logic        snapSpace, snapWrite;
  logic [23:0] snapOffset;
  logic [3:0]  snapLanes;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_slave_decoder u_dut (
    .clk(clk), .rstN(rstN), .strapNarrow(strapNarrow),
    .busAddrStrobe(busAddrStrobe), .busDataStrobe(busDataStrobe),
    .busAm(busAm), .busAddr(busAddr), .busLanes(busLanes), .busWrite(busWrite),
    .busAck(busAck), .busBerr(busBerr), .locReq(locReq), .locSpace(locSpace),
    .locOffset(locOffset), .locLanes(locLanes), .locWrite(locWrite),
    .locAck(locAck)
  );

  // Local bus responder: acknowledges after two waiting clocks when enabled
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      locAck = 1'b0;
      if (locReq) begin
        reqCycles++;
        snapSpace = locSpace; snapOffset = locOffset;
        snapLanes = locLanes; snapWrite = locWrite;
        if (respOn) begin
          if (waitCnt == 2) begin locAck = 1'b1; waitCnt = 0; end
          else waitCnt++;
        end
      end else begin
        waitCnt = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic openCycle(input logic [5:0] am, input logic [31:0] addr);
    @(negedge clk);
    busAm = am; busAddr = addr; busAddrStrobe = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic closeCycle();
    busAddrStrobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // One data-strobe beat; checks the reply kind and its one-clock width
  task automatic doBeat(input logic [3:0] lanes, input logic wr, input int expKind,
                        input string req);
    int got = EXP_NONE;
    int limit = (expKind == EXP_NONE) ? 20 : TIMEOUT + 40;
    busLanes = lanes; busWrite = wr; busDataStrobe = 1'b1;
    reqCycles = 0;
    for (int i = 0; i < limit && got == EXP_NONE; i++) begin
      @(negedge clk);
      if (busAck && busBerr) got = 3;
      else if (busAck) got = EXP_ACK;
      else if (busBerr) got = EXP_BERR;
    end
    check(got == expKind, req, "reply kind", got, expKind);
    if (got != EXP_NONE) begin
      @(negedge clk);
      check(!busAck && !busBerr, "R9", "reply pulse width", {busAck, busBerr}, 0);
    end
    busDataStrobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    check(!busAck && !busBerr && !locReq, "R9", "outputs idle after reset",
          {busAck, busBerr, locReq}, 0);
  endtask

  task automatic testShortSpace();
    strapNarrow = 1'b0;
    openCycle(6'h29, 32'h0000_C047);
    doBeat(4'b0011, 1'b0, EXP_ACK, "R1");
    check(snapSpace == 1'b0 && snapOffset == 24'h7, "R1", "short space/offset",
          {snapSpace, snapOffset}, 24'h7);
    closeCycle();
    openCycle(6'h2D, 32'h0000_C07C);
    doBeat(4'b1111, 1'b1, EXP_ACK, "R1");
    check(snapOffset == 24'h3C && snapWrite, "R1", "offset and write",
          {snapWrite, snapOffset}, {1'b1, 24'h3C});
    closeCycle();
    openCycle(6'h29, 32'h0000_C087);
    doBeat(4'b1111, 1'b0, EXP_NONE, "R4");
    check(reqCycles == 0, "R4", "short miss raises no request", reqCycles, 0);
    closeCycle();
  endtask

  task automatic testWide();
    logic [5:0] codes [6] = '{6'h09, 6'h0A, 6'h0D, 6'h0E, 6'h0B, 6'h0F};
    strapNarrow = 1'b0;
    foreach (codes[k]) begin
      openCycle(codes[k], 32'h2012_3454);
      doBeat(4'b0001, 1'b0, EXP_ACK, "R2");
      check(snapSpace && snapOffset == 24'h12_3454, "R2", "wide offset",
            snapOffset, 24'h12_3454);
      closeCycle();
    end
  endtask

  task automatic testNarrow();
    logic [5:0] codes [6] = '{6'h39, 6'h3A, 6'h3D, 6'h3E, 6'h3B, 6'h3F};
    strapNarrow = 1'b1;
    foreach (codes[k]) begin
      openCycle(codes[k], 32'h0051_2340);
      doBeat(4'b1100, 1'b1, EXP_ACK, "R3");
      check(snapSpace && snapOffset == 24'h11_2340, "R3", "narrow offset",
            snapOffset, 24'h11_2340);
      closeCycle();
    end
    strapNarrow = 1'b0;
  endtask

  task automatic ignoredCase(input logic strap, input logic [5:0] am,
                             input logic [31:0] addr);
    strapNarrow = strap;
    openCycle(am, addr);
    doBeat(4'b1111, 1'b0, EXP_NONE, "R4");
    check(reqCycles == 0, "R4", "ignored cycle raised request", reqCycles, 0);
    closeCycle();
  endtask

  task automatic testIgnored();
    ignoredCase(1'b1, 6'h09, 32'h2000_0000);
    ignoredCase(1'b0, 6'h39, 32'h0040_0000);
    ignoredCase(1'b0, 6'h08, 32'h2000_0000);
    ignoredCase(1'b0, 6'h2E, 32'h0000_C040);
    ignoredCase(1'b0, 6'h0D, 32'h2100_0000);
    ignoredCase(1'b1, 6'h3D, 32'h0080_0000);
    strapNarrow = 1'b0;
  endtask

  task automatic testLanes();
    for (int p = 0; p < 16; p++) begin
      logic [3:0] lanes = 4'(p);
      bit legal = (lanes inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                 4'b0011, 4'b1100, 4'b1111});
      openCycle(6'h09, 32'h2000_0010);
      if (legal) begin
        doBeat(lanes, 1'b1, EXP_ACK, "R5");
        check(snapLanes == lanes && snapWrite, "R5", "lanes echoed",
              snapLanes, lanes);
      end else begin
        doBeat(lanes, 1'b0, EXP_BERR, "R6");
        check(reqCycles == 0, "R6", "illegal lanes raised request", reqCycles, 0);
      end
      closeCycle();
    end
  endtask

  task automatic testTimeout();
    respOn = 1'b0;
    openCycle(6'h0E, 32'h2000_0200);
    doBeat(4'b1111, 1'b0, EXP_BERR, "R7");
    check(reqCycles == TIMEOUT, "R7", "request held clocks", reqCycles, TIMEOUT);
    check(!locReq, "R7", "request dropped after timeout", locReq, 0);
    closeCycle();
    respOn = 1'b1;
  endtask

  task automatic testBlock();
    logic [3:0]  lanes [4] = '{4'b1111, 4'b1111, 4'b0011, 4'b0001};
    logic [23:0] offs  [4] = '{24'h100, 24'h104, 24'h108, 24'h10A};
    openCycle(6'h0B, 32'h2000_0100);
    foreach (lanes[k]) begin
      doBeat(lanes[k], 1'b0, EXP_ACK, "R8");
      check(snapOffset == offs[k], "R8", "block beat offset", snapOffset, offs[k]);
    end
    closeCycle();
    openCycle(6'h09, 32'h2000_0100);
    doBeat(4'b1111, 1'b0, EXP_ACK, "R8");
    doBeat(4'b1111, 1'b0, EXP_NONE, "R8");
    check(reqCycles == 0, "R8", "second beat of single cycle", reqCycles, 0);
    closeCycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testShortSpace();
    testWide();
    testNarrow();
    testIgnored();
    testLanes();
    testTimeout();
    testBlock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule